// File: doc/BRIEF.md
# Host Indirect Memory Access Port

This block is a small host-side I/O register window. It gives a host bus byte access to two local memories, an SRAM and a Flash. The host does not map those memories directly. Instead it loads a 15-bit pointer and reads or writes through data ports. Each data-port access moves the pointer forward by one, so a host can stream a block of bytes with repeated accesses to a single port.

A configuration byte selects the target memory, two bank bits and the window size. The bank bits sit above the pointer to form a 17-bit local address. Only the low six host address bits are decoded, so higher address bits alias. In the wide window mode, a 32-entry register bank that lives outside the block is reached through a simple byte port.

The top 16 bytes of Flash hold the embedded processor's reset entry code. Host writes aimed there are dropped and recorded in a sticky flag.

Top module: `hostmem_port`

## Requirements
- R1: After reset, `host_rvalid`, `host_busy`, `mem_req` and `resv_viol` are 0, and offsets 0 to 3 read back as 0.
- R2: An access is honoured only while `host_ce` is 1. Only `host_addr[5:0]` is decoded, so any value of the higher address bits reaches the same register.
- R3: Offset 0 is a free 8-bit general byte. Offset 1 is the selector byte. Both are readable and writable.
- R4: Offset 2 holds pointer bits 7:0 and offset 3 holds pointer bits 14:8. Bit 7 written to offset 3 is discarded and reads back as 0. Writing either pointer byte never increments the pointer.
- R5: `mem_addr` equals {selector[4:3], pointer}. `mem_flash` equals selector bit 5, where 1 selects Flash and 0 selects SRAM.
- R6: A host read or write at any of offsets 4 to 7 raises `mem_req` (with `mem_we` set for writes) on the next clock edge. It is held with a stable address until a cycle with `mem_ack` high, then drops. The pointer is one higher on the cycle after that ack. Read data appears on `host_rdata` with `host_rvalid` high on the cycle after the ack.
- R7: The pointer increments from 7FFFh to 0000h, and the bank bits stay unchanged.
- R8: With selector bit 2 at 0, offsets 8 to 63 read as 0 and ignore writes. With bit 2 at 1, offsets 8 to 39 reach register-bank entry (offset − 8) through `rf_*`, and offsets 40 to 63 read as 0.
- R9: A data-port write while `mem_flash` is 1 and `mem_addr` is 1FFF0h or above issues no memory request. It sets `resv_viol`, which stays 1 until reset, and it still increments the pointer. Reads of that region proceed normally.
- R10: While `host_busy` is 1 (a memory request is outstanding), host strobes are ignored.
- R11: A read of any offset other than 4 to 7 returns its value with `host_rvalid` high on the cycle after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_ce | input | 1 | Card enable; strobes count only while high |
| host_addr | input | 10 | Host I/O address; bits 5:0 decoded |
| host_wr | input | 1 | Single-cycle write strobe |
| host_rd | input | 1 | Single-cycle read strobe |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Returned read byte |
| host_rvalid | output | 1 | One-cycle read data valid |
| host_busy | output | 1 | Memory access outstanding |
| mem_req | output | 1 | Memory request, held until ack |
| mem_we | output | 1 | Request is a write |
| mem_flash | output | 1 | 1 targets Flash, 0 targets SRAM |
| mem_addr | output | 17 | Local memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte, valid with ack |
| mem_ack | input | 1 | Memory acknowledge |
| rf_wr | output | 1 | Register-bank write strobe |
| rf_idx | output | 5 | Register-bank entry index |
| rf_wdata | output | 8 | Register-bank write byte |
| rf_rdata | input | 8 | Register-bank read byte for `rf_idx` |
| resv_viol | output | 1 | Sticky reserved-write flag |

## Verification
The hardest situation to reach is a host strobe that arrives while a data-port access is still waiting for its acknowledge. Every ordinary host task waits for the port to go idle first. The bench therefore stretches the memory model's acknowledge latency and issues a register write on the cycle right after a data-port read strobe. It then reads the register to show that the write was lost. Reaching the protected Flash bytes and the pointer wrap also needs set-up steps: the pointer is loaded with the last addresses of a bank, and the selector is set to Flash with both bank bits high.

// File: rtl/hmp_pkg.sv
package hmp_pkg;
   typedef enum logic [2:0] {
      RG_GEN,
      RG_SEL,
      RG_PLO,
      RG_PHI,
      RG_DATA,
      RG_RFILE,
      RG_NONE
   } hmp_region_e;

   localparam int OFF_GEN      = 0;
   localparam int OFF_SEL      = 1;
   localparam int OFF_PLO      = 2;
   localparam int OFF_PHI      = 3;
   localparam int OFF_DATA_LO  = 4;
   localparam int OFF_DATA_HI  = 7;
   localparam int OFF_RF_BASE  = 8;
   localparam int DEC_BITS     = 6;
   localparam int SEL_FLASH    = 5;
   localparam int SEL_BANK_LSB = 3;
   localparam int SEL_WIDE     = 2;
endpackage

// File: rtl/hmp_decode.sv
module hmp_decode
   import hmp_pkg::*;
#(
   parameter int RF_N          = 32,
   parameter bit EXT_WINDOW_EN = 1'b1,
   localparam int RF_IW        = (RF_N > 1) ? $clog2(RF_N) : 1
) (
   input  logic [DEC_BITS-1:0] off,
   input  logic                wide,
   output hmp_region_e         region,
   output logic [RF_IW-1:0]    rf_idx
);
   localparam logic [DEC_BITS-1:0] RF_BASE_V = DEC_BITS'(OFF_RF_BASE);
   localparam logic [DEC_BITS:0]   RF_END_V  = (DEC_BITS+1)'(OFF_RF_BASE + RF_N);

   logic rf_hit;

   generate
      if (OFF_RF_BASE + RF_N > (1 << DEC_BITS)) begin : g_bad_rf
         $error("hmp_decode: register bank does not fit the decoded window");
      end
      if (EXT_WINDOW_EN) begin : g_wide
         assign rf_hit = wide && (off >= RF_BASE_V) && ({1'b0, off} < RF_END_V);
      end else begin : g_narrow
         logic unused_wide;
         assign unused_wide = wide;
         assign rf_hit = 1'b0;
      end
   endgenerate

   assign rf_idx = RF_IW'(off - RF_BASE_V);

   always_comb begin
      region = RG_NONE;
      if (off == DEC_BITS'(OFF_GEN))        region = RG_GEN;
      else if (off == DEC_BITS'(OFF_SEL))   region = RG_SEL;
      else if (off == DEC_BITS'(OFF_PLO))   region = RG_PLO;
      else if (off == DEC_BITS'(OFF_PHI))   region = RG_PHI;
      else if (off >= DEC_BITS'(OFF_DATA_LO) && off <= DEC_BITS'(OFF_DATA_HI))
                                             region = RG_DATA;
      else if (rf_hit)                       region = RG_RFILE;
   end
endmodule

// File: rtl/hmp_pointer.sv
module hmp_pointer #(
   parameter int PTR_W  = 15,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_lo,
   input  logic              ld_hi,
   input  logic              inc,
   input  logic [DATA_W-1:0] wdata,
   output logic [PTR_W-1:0]  ptr
);
   localparam int HI_W = PTR_W - DATA_W;

   generate
      if (HI_W < 1 || HI_W > DATA_W) begin : g_bad_w
         $error("hmp_pointer: pointer must span two bytes");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr <= '0;
      end else if (ld_lo) begin
         ptr[DATA_W-1:0] <= wdata;
      end else if (ld_hi) begin
         ptr[PTR_W-1:DATA_W] <= wdata[HI_W-1:0];
      end else if (inc) begin
         ptr <= ptr + 1'b1;
      end
   end
endmodule

// File: rtl/hmp_mem_seq.sv
module hmp_mem_seq #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              start_we,
   input  logic [DATA_W-1:0] start_wdata,
   input  logic              mem_ack,
   output logic              mem_req,
   output logic              mem_we,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              done
);
   logic req_q;

   assign mem_req = req_q;
   assign done    = req_q && mem_ack;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_q     <= 1'b0;
         mem_we    <= 1'b0;
         mem_wdata <= '0;
      end else if (start) begin
         req_q     <= 1'b1;
         mem_we    <= start_we;
         mem_wdata <= start_wdata;
      end else if (done) begin
         req_q     <= 1'b0;
      end
   end
endmodule

// File: rtl/hostmem_port.sv
module hostmem_port
   import hmp_pkg::*;
#(
   parameter int HOST_AW       = 10,
   parameter int DATA_W        = 8,
   parameter int PTR_W         = 15,
   parameter int BANK_W        = 2,
   parameter int RF_N          = 32,
   parameter int RESV_BYTES    = 16,
   parameter bit EXT_WINDOW_EN = 1'b1,
   localparam int MEM_AW       = PTR_W + BANK_W,
   localparam int RF_IW        = (RF_N > 1) ? $clog2(RF_N) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               host_ce,
   input  logic [HOST_AW-1:0] host_addr,
   input  logic               host_wr,
   input  logic               host_rd,
   input  logic [DATA_W-1:0]  host_wdata,
   output logic [DATA_W-1:0]  host_rdata,
   output logic               host_rvalid,
   output logic               host_busy,
   output logic               mem_req,
   output logic               mem_we,
   output logic               mem_flash,
   output logic [MEM_AW-1:0]  mem_addr,
   output logic [DATA_W-1:0]  mem_wdata,
   input  logic [DATA_W-1:0]  mem_rdata,
   input  logic               mem_ack,
   output logic               rf_wr,
   output logic [RF_IW-1:0]   rf_idx,
   output logic [DATA_W-1:0]  rf_wdata,
   input  logic [DATA_W-1:0]  rf_rdata,
   output logic               resv_viol
);
   localparam logic [MEM_AW-1:0] RESV_ADDR = MEM_AW'((1 << MEM_AW) - RESV_BYTES);
   localparam int PHI_W = PTR_W - DATA_W;

   generate
      if (HOST_AW < DEC_BITS) begin : g_bad_aw
         $error("hostmem_port: host address narrower than decode");
      end
      if (DATA_W < SEL_FLASH + 1) begin : g_bad_dw
         $error("hostmem_port: selector byte too narrow");
      end
      if (SEL_BANK_LSB + BANK_W > SEL_FLASH) begin : g_bad_bank
         $error("hostmem_port: bank field overlaps memory select bit");
      end
      if (RESV_BYTES < 1 || RESV_BYTES > (1 << PTR_W)) begin : g_bad_resv
         $error("hostmem_port: reserved region size out of range");
      end
   endgenerate

   logic [DATA_W-1:0]   gen_q;
   logic [DATA_W-1:0]   sel_q;
   logic [PTR_W-1:0]    ptr_q;
   logic [DEC_BITS-1:0] off;
   logic                unused_addr_hi;
   hmp_region_e         region;
   logic                wr_go, rd_go, data_go, drop, start, done;
   logic                resv_hit;
   logic [DATA_W-1:0]   reg_rd_val;

   generate
      if (HOST_AW > DEC_BITS) begin : g_alias
         assign unused_addr_hi = ^host_addr[HOST_AW-1:DEC_BITS];
      end else begin : g_noalias
         assign unused_addr_hi = 1'b0;
      end
   endgenerate

   assign off     = host_addr[DEC_BITS-1:0];
   assign wr_go   = host_ce && !host_busy && host_wr;
   assign rd_go   = host_ce && !host_busy && host_rd && !host_wr;

   hmp_decode #(
      .RF_N          (RF_N),
      .EXT_WINDOW_EN (EXT_WINDOW_EN)
   ) u_dec (
      .off    (off),
      .wide   (sel_q[SEL_WIDE]),
      .region (region),
      .rf_idx (rf_idx)
   );

   assign mem_addr  = {sel_q[SEL_BANK_LSB +: BANK_W], ptr_q};
   assign mem_flash = sel_q[SEL_FLASH];
   assign resv_hit  = mem_flash && (mem_addr >= RESV_ADDR);

   assign data_go   = (wr_go || rd_go) && (region == RG_DATA);
   assign drop      = wr_go && (region == RG_DATA) && resv_hit;
   assign start     = data_go && !drop;

   hmp_pointer #(
      .PTR_W  (PTR_W),
      .DATA_W (DATA_W)
   ) u_ptr (
      .clk   (clk),
      .rst_n (rst_n),
      .ld_lo (wr_go && region == RG_PLO),
      .ld_hi (wr_go && region == RG_PHI),
      .inc   (done || drop),
      .wdata (host_wdata),
      .ptr   (ptr_q)
   );

   hmp_mem_seq #(
      .DATA_W (DATA_W)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .start_we    (wr_go),
      .start_wdata (host_wdata),
      .mem_ack     (mem_ack),
      .mem_req     (mem_req),
      .mem_we      (mem_we),
      .mem_wdata   (mem_wdata),
      .done        (done)
   );

   assign host_busy = mem_req;
   assign rf_wr     = wr_go && (region == RG_RFILE);
   assign rf_wdata  = host_wdata;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gen_q     <= '0;
         sel_q     <= '0;
         resv_viol <= 1'b0;
      end else begin
         if (wr_go && region == RG_GEN) gen_q <= host_wdata;
         if (wr_go && region == RG_SEL) sel_q <= host_wdata;
         if (drop)                      resv_viol <= 1'b1;
      end
   end

   always_comb begin
      case (region)
         RG_GEN:   reg_rd_val = gen_q;
         RG_SEL:   reg_rd_val = sel_q;
         RG_PLO:   reg_rd_val = ptr_q[DATA_W-1:0];
         RG_PHI:   reg_rd_val = DATA_W'(ptr_q[PTR_W-1 -: PHI_W]);
         RG_RFILE: reg_rd_val = rf_rdata;
         default:  reg_rd_val = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         host_rvalid <= 1'b0;
         host_rdata  <= '0;
      end else begin
         host_rvalid <= 1'b0;
         if (rd_go && region != RG_DATA) begin
            host_rvalid <= 1'b1;
            host_rdata  <= reg_rd_val;
         end else if (done && !mem_we) begin
            host_rvalid <= 1'b1;
            host_rdata  <= mem_rdata;
         end
      end
   end
endmodule

// File: rtl/hmp_checker.sv
module hmp_checker #(
   parameter int PTR_W      = 15,
   parameter int BANK_W     = 2,
   parameter int RESV_BYTES = 16,
   localparam int MEM_AW    = PTR_W + BANK_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mem_req,
   input logic              mem_ack,
   input logic              mem_we,
   input logic              mem_flash,
   input logic [MEM_AW-1:0] mem_addr,
   input logic [PTR_W-1:0]  ptr,
   input logic              viol,
   input logic              host_rvalid
);
   localparam logic [MEM_AW-1:0] RESV_ADDR = MEM_AW'((1 << MEM_AW) - RESV_BYTES);

   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R6

   AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_ack |=> !mem_req); // R6

   AST_READ_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_ack && !mem_we |=> host_rvalid); // R6

   AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_ack |=> ptr == PTR_W'($past(ptr) + 1'b1)); // R7

   AST_BANK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_ack |=> mem_addr[MEM_AW-1 -: BANK_W] == $past(mem_addr[MEM_AW-1 -: BANK_W])); // R7

   AST_NO_RESV_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we && mem_flash |-> mem_addr < RESV_ADDR); // R9

   AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      viol |=> viol); // R9
endmodule

bind hostmem_port hmp_checker #(
   .PTR_W      (PTR_W),
   .BANK_W     (BANK_W),
   .RESV_BYTES (RESV_BYTES)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .mem_req     (mem_req),
   .mem_ack     (mem_ack),
   .mem_we      (mem_we),
   .mem_flash   (mem_flash),
   .mem_addr    (mem_addr),
   .ptr         (ptr_q),
   .viol        (resv_viol),
   .host_rvalid (host_rvalid)
);

// File: tb/hostmem_port_tb.sv
module hostmem_port_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_ce = 1'b0;
   logic [9:0]  host_addr = '0;
   logic        host_wr = 1'b0;
   logic        host_rd = 1'b0;
   logic [7:0]  host_wdata = '0;
   logic [7:0]  host_rdata;
   logic        host_rvalid, host_busy;
   logic        mem_req, mem_we, mem_flash;
   logic [16:0] mem_addr;
   logic [7:0]  mem_wdata;
   logic [7:0]  mem_rdata = '0;
   logic        mem_ack = 1'b0;
   logic        rf_wr;
   logic [4:0]  rf_idx;
   logic [7:0]  rf_wdata, rf_rdata;
   logic        resv_viol;

   int n_chk = 0;
   int n_err = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   hostmem_port dut_i (
      .clk(clk), .rst_n(rst_n), .host_ce(host_ce), .host_addr(host_addr),
      .host_wr(host_wr), .host_rd(host_rd), .host_wdata(host_wdata),
      .host_rdata(host_rdata), .host_rvalid(host_rvalid), .host_busy(host_busy),
      .mem_req(mem_req), .mem_we(mem_we), .mem_flash(mem_flash),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .mem_ack(mem_ack), .rf_wr(rf_wr), .rf_idx(rf_idx), .rf_wdata(rf_wdata),
      .rf_rdata(rf_rdata), .resv_viol(resv_viol)
   );

   // memory and register-bank models
   logic [7:0] sram_m [int];
   logic [7:0] flash_m [int];
   logic [7:0] rf_m [32];
   int  flash_wr_cnt = 0;
   int  lat_cfg = -1;
   int  wait_cnt = 0;

   assign rf_rdata = rf_m[rf_idx];

   function automatic logic [7:0] mget(bit fl, int a);
      if (fl) return flash_m.exists(a) ? flash_m[a] : 8'h00;
      return sram_m.exists(a) ? sram_m[a] : 8'h00;
   endfunction

   always @(posedge clk) begin
      if (rf_wr) rf_m[rf_idx] <= rf_wdata;
      if (!rst_n) begin
         mem_ack <= 1'b0;
      end else if (mem_req && !mem_ack) begin
         if (wait_cnt == 0) begin
            mem_ack <= 1'b1;
            if (mem_we) begin
               if (mem_flash) begin
                  flash_m[int'(mem_addr)] = mem_wdata;
                  flash_wr_cnt++;
               end else begin
                  sram_m[int'(mem_addr)] = mem_wdata;
               end
            end else begin
               mem_rdata <= mget(mem_flash, int'(mem_addr));
            end
            wait_cnt <= (lat_cfg < 0) ? int'($urandom % 3) : lat_cfg;
         end else begin
            wait_cnt <= wait_cnt - 1;
         end
      end else begin
         mem_ack <= 1'b0;
      end
   end

   // expected state
   logic [7:0]  e_gen = 0, e_sel = 0;
   logic [14:0] e_ptr = 0;

   function automatic int e_addr();
      return int'({e_sel[4:3], e_ptr});
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [9:0] alias_of(int off);
      return {4'($urandom), 6'(off)};
   endfunction

   task automatic hwrite(int off, logic [7:0] d, bit ce = 1);
      @(negedge clk);
      host_addr = alias_of(off); host_wdata = d; host_wr = 1; host_ce = ce;
      @(negedge clk);
      host_wr = 0; host_ce = 0;
      while (host_busy) @(negedge clk);
   endtask

   task automatic hread(int off, output logic [7:0] d, output int lat);
      @(negedge clk);
      host_addr = alias_of(off); host_rd = 1; host_ce = 1;
      @(negedge clk);
      host_rd = 0; host_ce = 0;
      lat = 1;
      while (!host_rvalid) begin @(negedge clk); lat++; end
      d = host_rdata;
   endtask

   task automatic set_sel(logic [7:0] v);
      hwrite(1, v); e_sel = v;
   endtask

   task automatic set_ptr(logic [14:0] p);
      hwrite(2, p[7:0]); hwrite(3, {1'b1, p[14:8]}); e_ptr = p;
   endtask

   task automatic chk_ptr(string req);
      logic [7:0] lo, hi; int l;
      hread(2, lo, l); hread(3, hi, l);
      chk(req, {hi, lo}, {1'b0, e_ptr});
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_err++; n_chk++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin : main
      logic [7:0] d; int lat; int a; int cnt0;
      logic [7:0] vals [4];
      void'($urandom(32'h5eed_1234));
      for (int i = 0; i < 32; i++) rf_m[i] = 8'(i * 7 + 3);
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1;

      // R1 reset state
      chk("R1 rvalid", host_rvalid, 0);
      chk("R1 busy", host_busy, 0);
      chk("R1 req", mem_req, 0);
      chk("R1 viol", resv_viol, 0);
      for (int o = 0; o < 4; o++) begin
         hread(o, d, lat);
         chk("R1 reg zero", d, 0);
      end

      // R3 general byte and selector, with aliased addresses (R2)
      hwrite(0, 8'hA5); e_gen = 8'hA5;
      hread(0, d, lat);
      chk("R3 gen byte", d, e_gen);
      chk("R11 register read latency", lat, 1);
      set_sel(8'hC3);
      hread(1, d, lat);
      chk("R3 selector", d, 8'hC3);
      set_sel(8'h00);

      // R2 card enable low ignored
      hwrite(0, 8'h11, 0);
      hread(0, d, lat);
      chk("R2 ce low ignored", d, e_gen);

      // R4 pointer bytes, bit 15 discarded, no increment
      set_ptr(15'h7234);
      chk("R4 no request on pointer write", mem_req, 0);
      chk_ptr("R4 pointer readback");

      // R5/R6 data write and read, SRAM bank 01
      set_sel(8'h08);
      set_ptr(15'h1234);
      hwrite(5, 8'h9C);
      a = e_addr(); e_ptr++;
      chk("R5 sram addressed", mget(0, a), 8'h9C);
      chk("R5 flash untouched", flash_m.exists(a), 0);
      chk_ptr("R6 increment after write");
      set_ptr(15'h1234);
      hread(7, d, lat);
      e_ptr++;
      chk("R6 read data", d, 8'h9C);
      chk_ptr("R6 increment after read");

      // R7 wrap in Flash bank 10
      set_sel(8'h30);
      set_ptr(15'h7FFF);
      hwrite(4, 8'h5A);
      chk("R7 flash at bank top", mget(1, 17'h17FFF), 8'h5A);
      e_ptr = 0;
      chk_ptr("R7 pointer wrap");
      hread(1, d, lat);
      chk("R7 bank unchanged", d, 8'h30);

      // R9 reserved Flash region
      set_sel(8'h38);
      set_ptr(15'h7FF0);
      cnt0 = flash_wr_cnt;
      hwrite(6, 8'hEE);
      e_ptr++;
      chk("R9 write dropped", flash_wr_cnt, cnt0);
      chk("R9 not stored", flash_m.exists(17'h1FFF0), 0);
      chk("R9 viol set", resv_viol, 1);
      chk_ptr("R9 pointer still steps");
      flash_m[17'h1FFF1] = 8'h77;
      hread(4, d, lat);
      e_ptr++;
      chk("R9 reserved read allowed", d, 8'h77);
      set_sel(8'h18);
      set_ptr(15'h7FF0);
      hwrite(4, 8'h42);
      e_ptr++;
      chk("R9 sram top writable", mget(0, 17'h1FFF0), 8'h42);
      chk("R9 viol sticky", resv_viol, 1);

      // R8 window size
      set_sel(8'h00);
      hread(8, d, lat);
      chk("R8 narrow offset 8 zero", d, 0);
      hwrite(9, 8'hF0);
      chk("R8 narrow write ignored", rf_m[1], 8'(1 * 7 + 3));
      set_sel(8'h04);
      hwrite(13, 8'hB6);
      chk("R8 bank entry written", rf_m[5], 8'hB6);
      hread(13, d, lat);
      chk("R8 bank entry read", d, 8'hB6);
      hread(39, d, lat);
      chk("R8 last entry", d, rf_m[31]);
      hread(40, d, lat);
      chk("R8 beyond window zero", d, 0);

      // R10 strobe while busy ignored
      lat_cfg = 4;
      @(negedge clk);
      host_addr = alias_of(4); host_rd = 1; host_ce = 1;
      @(negedge clk);
      host_rd = 0; host_wr = 1; host_addr = alias_of(0); host_wdata = 8'h55;
      chk("R10 busy during strobe", host_busy, 1);
      @(negedge clk);
      host_wr = 0; host_ce = 0;
      while (!host_rvalid) @(negedge clk);
      e_ptr++;
      lat_cfg = -1;
      hread(0, d, lat);
      chk("R10 busy write ignored", d, e_gen);

      // R6 random streaming through SRAM with aliased data ports
      for (int it = 0; it < 30; it++) begin
         logic [14:0] p0;
         int n;
         set_sel({2'b00, 1'b0, 2'($urandom), 3'b000});
         p0 = 15'($urandom);
         set_ptr(p0);
         n = 1 + int'($urandom % 4);
         for (int k = 0; k < n; k++) begin
            vals[k] = 8'($urandom);
            hwrite(4 + int'($urandom % 4), vals[k]);
            e_ptr++;
         end
         set_ptr(p0);
         for (int k = 0; k < n; k++) begin
            hread(4 + int'($urandom % 4), d, lat);
            e_ptr++;
            chk("R6 random stream", d, vals[k]);
         end
         chk_ptr("R6 random pointer");
      end

      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule